// File: doc/BRIEF.md
# Timer Capture Channel with Synchronous Capture

This block contains a free-running up-counter and one capture channel. The counter advances on each rising edge of an external timer clock. That clock is sampled in the system clock domain and never used as a real clock. The channel watches one of four trigger sources: two external pins, a constant low and a constant high. When the chosen edge occurs, the channel copies the counter into a capture register, sets a capture flag and may raise an interrupt request. Software can switch the source between the two constant levels, which gives a software-generated edge that the channel treats like an external one.

Capture works in one of two ways. In asynchronous mode a qualifying edge loads the counter at once. In synchronous mode the edge is only remembered, and the load happens at the next falling edge of the timer clock. This catches trigger pulses that begin and end inside a single phase of the timer clock, even though the counter moves on the rising edge in between. A small register interface sets the mode, reads the counter, the capture value and the status, and clears the flags with write-one-to-clear.

Register map (2-bit address): 0 control, 1 counter (read), 2 capture value (read), 3 status. Control fields: bits [1:0] edge select, bits [3:2] source select, bit 4 synchronous mode, bit 5 interrupt enable, bit 6 counter clear (a write-only strobe, read as 0). Status fields: bit 0 live trigger level, bit 1 latched trigger level, bit 2 capture flag, bit 3 capture-overflow flag.

Top module: `tcap_channel`

## Requirements
- R1: After reset the counter is 0. It goes up by exactly one for each rising edge of the timer clock input and does not change on falling edges.
- R2: Writing control with bit 6 set clears the counter to 0. Bit 6 always reads back as 0.
- R3: Control bits [1:0] choose the capture edge: 0 never captures, 1 captures on rising edges, 2 on falling edges, 3 on both. An edge of the other polarity causes no capture.
- R4: Control bits [3:2] choose the trigger: 0 external input A, 1 external input B, 2 constant low, 3 constant high. Changing the selection from 2 to 3 is a rising edge. Activity on a pin that is not selected has no effect.
- R5: With control bit 4 clear, a qualifying edge loads the current counter value into the capture register and sets the capture flag without waiting for the timer clock.
- R6: With control bit 4 set, a qualifying edge does not set the capture flag. The capture takes place at the next falling edge of the timer clock and records the counter value at that moment.
- R7: In synchronous mode, a trigger pulse that rises and falls entirely while the timer clock is low, or entirely while it is high, is still captured at the next falling timer clock edge. The counter advances at the rising edge in between.
- R8: In synchronous mode, several qualifying edges before one falling timer clock edge produce exactly one capture and no overflow.
- R9: The capture flag (status bit 2) stays set until software writes status with bit 2 set. The overflow flag (status bit 3) is cleared by writing status with bit 3 set. Each clear acts only on its own flag.
- R10: A capture that happens while the capture flag is still set also sets the overflow flag and updates the capture value.
- R11: Status bit 0 shows the live level of the selected trigger. Status bit 1 holds the trigger level sampled at the most recent capture.
- R12: The interrupt request output is high exactly when the capture flag is set and control bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmrClkIn | input | 1 | External timer clock, sampled as data |
| trigA | input | 1 | External trigger input A (asynchronous) |
| trigB | input | 1 | External trigger input B (asynchronous) |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | DATA_W | Register write data |
| rdData | output | DATA_W | Register read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a 16-bit data bus and two-stage synchronizers. With these values the counter stays far from wrapping, so every expected capture value is a small count that the bench tracks itself. The two-stage synchronizer gives a fixed three-cycle path from a pin to a register. This lets the bench toggle the timer clock and triggers one phase at a time and reach both single-phase pulse cases, a pulse inside the low phase and one inside the high phase, as well as several edges merging into one pending capture and an overflow built from a rising and a falling edge.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edgeMode_e;

  typedef enum logic [1:0] {
    SRC_EXT_A     = 2'd0,
    SRC_EXT_B     = 2'd1,
    SRC_TIED_LOW  = 2'd2,
    SRC_TIED_HIGH = 2'd3
  } srcSel_e;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_COUNT   = 2'd1,
    REG_CAPTURE = 2'd2,
    REG_STATUS  = 2'd3
  } regAddr_e;

  localparam int CTRL_SYNC_BIT  = 4;
  localparam int CTRL_IRQEN_BIT = 5;
  localparam int CTRL_CLR_BIT   = 6;

  localparam int STAT_LIVE_BIT  = 0;
  localparam int STAT_LATCH_BIT = 1;
  localparam int STAT_CAP_BIT   = 2;
  localparam int STAT_OVF_BIT   = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic capLoad;
  } dpStrobe_t;

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmrLvl,
  input  logic              trigALvl,
  input  logic              trigBLvl,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output dpStrobe_t         strobe,
  output edgeMode_e         capMode,
  output srcSel_e           srcSel,
  output logic              syncMode,
  output logic              irqEn,
  output logic              selLevel,
  output logic              capFlag,
  output logic              ovfFlag,
  output logic              tmrFall
);

  logic tmrPrev;
  logic selPrev;
  logic tmrRise;
  logic selRise;
  logic selFall;
  logic qualEdge;
  logic capPending;
  logic ctrlWr;
  logic statWr;
  logic capNow;

  assign ctrlWr = wrEn && (addr == REG_CTRL);
  assign statWr = wrEn && (addr == REG_STATUS);

  // trigger source selection
  always_comb begin
    unique case (srcSel)
      SRC_EXT_A:     selLevel = trigALvl;
      SRC_EXT_B:     selLevel = trigBLvl;
      SRC_TIED_LOW:  selLevel = 1'b0;
      SRC_TIED_HIGH: selLevel = 1'b1;
      default:       selLevel = 1'b0;
    endcase
  end

  // edge detection in the system clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmrPrev <= 1'b0;
      selPrev <= 1'b0;
    end else begin
      tmrPrev <= tmrLvl;
      selPrev <= selLevel;
    end
  end

  assign tmrRise = tmrLvl && !tmrPrev;
  assign tmrFall = !tmrLvl && tmrPrev;
  assign selRise = selLevel && !selPrev;
  assign selFall = !selLevel && selPrev;

  always_comb begin
    unique case (capMode)
      EDGE_NONE: qualEdge = 1'b0;
      EDGE_RISE: qualEdge = selRise;
      EDGE_FALL: qualEdge = selFall;
      EDGE_BOTH: qualEdge = selRise || selFall;
      default:   qualEdge = 1'b0;
    endcase
  end

  // capture decision: immediate, or deferred to the falling timer edge
  assign capNow = syncMode ? (tmrFall && (capPending || qualEdge)) : qualEdge;

  always_comb begin
    strobe.cntInc  = tmrRise;
    strobe.cntClr  = ctrlWr && wrData[CTRL_CLR_BIT];
    strobe.capLoad = capNow;
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capMode  <= EDGE_NONE;
      srcSel   <= SRC_EXT_A;
      syncMode <= 1'b0;
      irqEn    <= 1'b0;
    end else if (ctrlWr) begin
      capMode  <= edgeMode_e'(wrData[1:0]);
      srcSel   <= srcSel_e'(wrData[3:2]);
      syncMode <= wrData[CTRL_SYNC_BIT];
      irqEn    <= wrData[CTRL_IRQEN_BIT];
    end
  end

  // single pending bit for synchronous capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capPending <= 1'b0;
    end else if (!syncMode || (capMode == EDGE_NONE) || tmrFall) begin
      capPending <= 1'b0;
    end else if (qualEdge) begin
      capPending <= 1'b1;
    end
  end

  // sticky flags, setting wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (capNow)                              capFlag <= 1'b1;
      else if (statWr && wrData[STAT_CAP_BIT]) capFlag <= 1'b0;

      if (capNow && capFlag)                   ovfFlag <= 1'b1;
      else if (statWr && wrData[STAT_OVF_BIT]) ovfFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/tcap_dpath.sv
module tcap_dpath
  import tcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic             selLevel,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] capVal,
  output logic             latchedLvl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cntVal <= '0;
    else if (strobe.cntClr) cntVal <= '0;
    else if (strobe.cntInc) cntVal <= cntVal + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capVal     <= '0;
      latchedLvl <= 1'b0;
    end else if (strobe.capLoad) begin
      capVal     <= cntVal;
      latchedLvl <= selLevel;
    end
  end

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
  import tcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmrClkIn,
  input  logic              trigA,
  input  logic              trigB,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int IN_W = 3;

  logic [IN_W-1:0] rawIn;
  logic [IN_W-1:0] syncIn;
  dpStrobe_t       strobe;
  edgeMode_e       capMode;
  srcSel_e         srcSel;
  logic            syncMode;
  logic            irqEn;
  logic            selLevel;
  logic            capFlag;
  logic            ovfFlag;
  logic            tmrFall;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] capVal;
  logic            latchedLvl;

  assign rawIn = {trigB, trigA, tmrClkIn};

  tcap_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  tcap_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmrLvl   (syncIn[0]),
    .trigALvl (syncIn[1]),
    .trigBLvl (syncIn[2]),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .strobe   (strobe),
    .capMode  (capMode),
    .srcSel   (srcSel),
    .syncMode (syncMode),
    .irqEn    (irqEn),
    .selLevel (selLevel),
    .capFlag  (capFlag),
    .ovfFlag  (ovfFlag),
    .tmrFall  (tmrFall)
  );

  tcap_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .selLevel   (selLevel),
    .cntVal     (cntVal),
    .capVal     (capVal),
    .latchedLvl (latchedLvl)
  );

  always_comb begin
    rdData = '0;
    unique case (addr)
      REG_CTRL: begin
        rdData[1:0]            = capMode;
        rdData[3:2]            = srcSel;
        rdData[CTRL_SYNC_BIT]  = syncMode;
        rdData[CTRL_IRQEN_BIT] = irqEn;
      end
      REG_COUNT:   rdData = DATA_W'(cntVal);
      REG_CAPTURE: rdData = DATA_W'(capVal);
      REG_STATUS: begin
        rdData[STAT_LIVE_BIT]  = selLevel;
        rdData[STAT_LATCH_BIT] = latchedLvl;
        rdData[STAT_CAP_BIT]   = capFlag;
        rdData[STAT_OVF_BIT]   = ovfFlag;
      end
      default: rdData = '0;
    endcase
  end

  assign irq = capFlag && irqEn;

endmodule

// File: rtl/tcap_channel_chk.sv
module tcap_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] capVal,
  input logic             capFlag,
  input logic             ovfFlag,
  input logic             capLoad,
  input logic             syncMode,
  input logic             tmrFall,
  input logic             irqEn,
  input logic             irq
);

  // R1: the counter only steps by one or returns to zero
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cntVal != $past(cntVal)) |-> ((cntVal == $past(cntVal) + CNT_W'(1)) || (cntVal == '0)));

  // R6: in synchronous mode the capture value moves only after a falling timer edge
  a_r6_sync_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(syncMode) && !$stable(capVal)) |-> $past(tmrFall));

  // R9: the capture flag rises only after a capture load
  a_r9_flag_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capFlag) |-> $past(capLoad));

  // R10: overflow needs a capture flag that was already set
  a_r10_ovf_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovfFlag) |-> $past(capFlag));

  // R12: no interrupt request without enable and flag
  a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irqEn && capFlag));

endmodule

bind tcap_channel tcap_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cntVal   (cntVal),
  .capVal   (capVal),
  .capFlag  (capFlag),
  .ovfFlag  (ovfFlag),
  .capLoad  (strobe.capLoad),
  .syncMode (syncMode),
  .tmrFall  (tmrFall),
  .irqEn    (irqEn),
  .irq      (irq)
);

// File: tb/tcap_channel_tb.sv
module tcap_channel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int SETTLE     = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tmrClkIn = 1'b0;
  logic              trigA = 1'b0;
  logic              trigB = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              irq;

  int testsRun = 0;
  int testsFailed = 0;
  logic [15:0] expCnt = 16'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcap_channel dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmrClkIn (tmrClkIn),
    .trigA    (trigA),
    .trigB    (trigB),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .rdData   (rdData),
    .irq      (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    settle();
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic tmrUp();
    @(negedge clk); tmrClkIn = 1'b1; expCnt++; settle();
  endtask

  task automatic tmrDown();
    @(negedge clk); tmrClkIn = 1'b0; settle();
  endtask

  task automatic setA(input logic v);
    @(negedge clk); trigA = v; settle();
  endtask

  task automatic setB(input logic v);
    @(negedge clk); trigB = v; settle();
  endtask

  task automatic clearFlags();
    wrReg(2'd3, 16'h000C);
  endtask

  task automatic testReset();
    logic [DATA_W-1:0] d;
    rdReg(2'd0, d); check("R1 ctrl after reset", d, 0);
    rdReg(2'd1, d); check("R1 counter after reset", d, 0);
    rdReg(2'd3, d); check("R9 status after reset", d, 0);
    check("R12 irq after reset", irq, 0);
  endtask

  task automatic testCount();
    logic [DATA_W-1:0] d;
    for (int i = 0; i < 4; i++) begin
      tmrUp();
      rdReg(2'd1, d); check("R1 count after rising edge", d, expCnt);
      tmrDown();
      rdReg(2'd1, d); check("R1 count held on falling edge", d, expCnt);
    end
  endtask

  task automatic testClear();
    logic [DATA_W-1:0] d;
    wrReg(2'd0, 16'h0040);
    expCnt = 0;
    rdReg(2'd1, d); check("R2 counter cleared", d, 0);
    rdReg(2'd0, d); check("R2 clear bit reads zero", d, 0);
    tmrUp(); tmrDown(); tmrUp(); tmrDown();
    rdReg(2'd1, d); check("R2 counts again after clear", d, expCnt);
  endtask

  task automatic testAsyncRise();
    logic [DATA_W-1:0] d;
    wrReg(2'd0, 16'h0001);          // rising, input A, async
    setA(1'b1);
    rdReg(2'd3, d); check("R5 async flag set", d[2], 1);
    check("R11 latched level high", d[1], 1);
    rdReg(2'd2, d); check("R5 async capture value", d, expCnt);
    tmrUp(); tmrDown();
    setA(1'b0);
    rdReg(2'd3, d); check("R3 falling edge ignored in rising mode", d[3], 0);
    rdReg(2'd2, d); check("R3 capture kept in rising mode", d, expCnt - 1);
    clearFlags();
  endtask

  task automatic testAsyncFall();
    logic [DATA_W-1:0] d;
    wrReg(2'd0, 16'h0002);          // falling, input A, async
    setA(1'b1);
    rdReg(2'd3, d); check("R3 rising edge ignored in falling mode", d[2], 0);
    tmrUp(); tmrDown();
    setA(1'b0);
    rdReg(2'd3, d); check("R3 falling edge captured", d[2], 1);
    check("R11 latched level low", d[1], 0);
    rdReg(2'd2, d); check("R3 falling capture value", d, expCnt);
    clearFlags();
  endtask

  task automatic testBothOverflow();
    logic [DATA_W-1:0] d;
    wrReg(2'd0, 16'h0007);          // both edges, input B, async
    setA(1'b1); setA(1'b0);
    rdReg(2'd3, d); check("R4 unselected input A ignored", d[2], 0);
    setB(1'b1);
    rdReg(2'd3, d); check("R10 first capture no overflow", d[3:2], 2'b01);
    tmrUp(); tmrDown();
    setB(1'b0);
    rdReg(2'd3, d); check("R10 second capture overflow", d[3:2], 2'b11);
    rdReg(2'd2, d); check("R10 capture value updated", d, expCnt);
    wrReg(2'd3, 16'h0004);
    rdReg(2'd3, d); check("R9 clear capture flag only", d[3:2], 2'b10);
    wrReg(2'd3, 16'h0008);
    rdReg(2'd3, d); check("R9 clear overflow flag", d[3:2], 2'b00);
  endtask

  task automatic testSoftEdge();
    logic [DATA_W-1:0] d;
    wrReg(2'd0, 16'h0009);          // rising, tied low
    rdReg(2'd3, d); check("R4 tied low no capture", d[2], 0);
    tmrUp(); tmrDown();
    wrReg(2'd0, 16'h000D);          // rising, tied high
    rdReg(2'd3, d); check("R4 software edge captured", d[2], 1);
    check("R11 live level tied high", d[0], 1);
    rdReg(2'd2, d); check("R4 software capture value", d, expCnt);
    clearFlags();
    setA(1'b1); setA(1'b0);
    rdReg(2'd3, d); check("R4 pin ignored while tied high", d[2], 0);
    wrReg(2'd0, 16'h0000);          // back to input A, no capture
    clearFlags();
  endtask

  task automatic testSyncLowPhase();
    logic [DATA_W-1:0] d;
    wrReg(2'd0, 16'h0013);          // both edges, input A, synchronous
    setA(1'b1);
    rdReg(2'd3, d); check("R6 no flag on sync edge", d[2], 0);
    setA(1'b0);
    rdReg(2'd3, d); check("R7 no flag during low phase pulse", d[2], 0);
    tmrUp();
    rdReg(2'd1, d); check("R7 counter advances at rising edge", d, expCnt);
    rdReg(2'd3, d); check("R6 no capture on rising timer edge", d[2], 0);
    tmrDown();
    rdReg(2'd3, d); check("R7 capture at falling edge low phase", d[3:2], 2'b01);
    check("R8 two edges one capture", d[3], 0);
    rdReg(2'd2, d); check("R6 sync capture value", d, expCnt);
    clearFlags();
  endtask

  task automatic testSyncHighPhase();
    logic [DATA_W-1:0] d;
    tmrUp();
    setA(1'b1); setA(1'b0);
    rdReg(2'd3, d); check("R7 no flag during high phase pulse", d[2], 0);
    tmrDown();
    rdReg(2'd3, d); check("R7 capture at falling edge high phase", d[2], 1);
    check("R8 no overflow high phase", d[3], 0);
    rdReg(2'd2, d); check("R7 high phase capture value", d, expCnt);
  endtask

  task automatic testIrq();
    logic [DATA_W-1:0] d;
    wrReg(2'd0, 16'h0000);          // flag still set, irq disabled
    check("R12 irq low when disabled", irq, 0);
    wrReg(2'd0, 16'h0020);
    check("R12 irq high with flag and enable", irq, 1);
    clearFlags();
    check("R12 irq low after flag clear", irq, 0);
    setA(1'b1); setA(1'b0);
    rdReg(2'd3, d); check("R3 mode zero never captures", d[2], 0);
    check("R12 irq stays low without capture", irq, 0);
  endtask

  task automatic testLive();
    logic [DATA_W-1:0] d;
    setA(1'b1);
    rdReg(2'd3, d); check("R11 live level follows input A high", d[0], 1);
    setA(1'b0);
    rdReg(2'd3, d); check("R11 live level follows input A low", d[0], 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle();
    testReset();
    testCount();
    testClear();
    testAsyncRise();
    testAsyncFall();
    testBothOverflow();
    testSoftEdge();
    testSyncLowPhase();
    testSyncHighPhase();
    testIrq();
    testLive();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule